// File: doc/BRIEF.md
# Lock-Guarded System Control Register File

This block is a small register file on a plain 32-bit read/write bus. It holds an LED word, two configuration words, a volatile flag word and a non-volatile flag word, and a 16-bit lock. A reset-control word sits behind that lock. Flag words have separate set and clear addresses, so software can change single bits without a read-modify-write. An identification word and a processor identification word are fixed by parameters.

The reset-control word takes a write only while the lock holds the unlock key 0xA05F. When a write is taken and the trigger bit is set, the block raises a one-cycle reset request. Which bit is the trigger, and whether the word exists at all, depends on the board-variant field in bits 27:16 of the identification parameter. Any access to an offset that is not decoded returns zero and raises a one-cycle error strobe.

There are two synchronous reset inputs. Power-on reset clears every register. Soft reset clears everything except the non-volatile flags.

Top module: `sysctl_regs`

## Requirements
- R1: While `por` is high, and after it is released, every stored register (LED 0x08, lock 0x20, configuration 0x28 and 0x2C, flags 0x30, non-volatile flags 0x38, reset control 0x40) reads zero. `rdata`, `err` and `reset_req` are also zero.
- R2: `soft_rst` clears every register that R1 lists except the non-volatile flags at 0x38, which keep their value.
- R3: A read (`rd_en` high) puts the addressed word on `rdata` after the next rising edge, and `rdata` holds it until the next read. 0x00 returns `ID_VALUE` and 0x84 returns `PROC_ID`; writes to either are errors.
- R4: The LED word at 0x08 and the configuration words at 0x28 and 0x2C store all 32 written bits and read them back.
- R5: The lock at 0x20 compares only bits 15:0 of the written data with 0xA05F. A match stores 0xA05F. Any other value stores bits 15:0 with bit 15 forced to zero. The lock reads back zero-extended.
- R6: A write to 0x30 ORs the data into the flags. A write to 0x34 clears every flag bit that is one in the data. The flags read at 0x30.
- R7: The non-volatile flags follow the same rule: set and read at 0x38, clear at 0x3C.
- R8: A write to 0x40 updates the reset-control word only while the lock reads 0xA05F. Otherwise the word keeps its value.
- R9: A write to 0x40 that is taken, with the trigger bit set, makes `reset_req` high for exactly the cycle after the write edge. The trigger bit is bit 8 for variant 0x100 and bit 2 for variants 0x178 and 0x182. No other write raises `reset_req`.
- R10: For every other variant, 0x40 reads zero with no error, ignores writes and never raises `reset_req`.
- R11: A read of an undecoded offset returns zero, and a write to an undecoded or read-only offset changes nothing. In both cases `err` is high for the cycle after the access edge. Reads of 0x34 and 0x3C count as undecoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high, clears all state |
| soft_rst | input | 1 | Synchronous soft reset, active high, keeps non-volatile flags |
| rd_en | input | 1 | Read strobe for one cycle |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W (12) | Byte offset of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| err | output | 1 | One-cycle strobe for an access to an undecoded offset |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions take for granted that `rd_en` and `wr_en` are never high in the same cycle. They also assume `por` is high from time zero, so that every past value they look at comes from a defined state. The stimulus drives exactly one access per cycle, changes inputs only at the falling edge, and holds `por` for several cycles at the start. A rule on the non-volatile flags during soft reset is only stated for cycles with no write, and the bench never pairs a write with `soft_rst`.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NREG = 11;

  localparam int IX_ID    = 0;
  localparam int IX_LED   = 1;
  localparam int IX_LOCK  = 2;
  localparam int IX_CFG0  = 3;
  localparam int IX_CFG1  = 4;
  localparam int IX_FSET  = 5;
  localparam int IX_FCLR  = 6;
  localparam int IX_NSET  = 7;
  localparam int IX_NCLR  = 8;
  localparam int IX_RCTL  = 9;
  localparam int IX_PROC  = 10;

  // offsets readable / writable, one bit per index above
  localparam logic [NREG-1:0] RD_MASK = 11'b110_1011_1111;
  localparam logic [NREG-1:0] WR_MASK = 11'b011_1111_1110;

  localparam logic [11:0] BRD_LEGACY = 12'h100;
  localparam logic [11:0] BRD_A      = 12'h178;
  localparam logic [11:0] BRD_B      = 12'h182;

  function automatic logic [11:0] reg_offset(input int idx);
    case (idx)
      IX_ID:   return 12'h000;
      IX_LED:  return 12'h008;
      IX_LOCK: return 12'h020;
      IX_CFG0: return 12'h028;
      IX_CFG1: return 12'h02C;
      IX_FSET: return 12'h030;
      IX_FCLR: return 12'h034;
      IX_NSET: return 12'h038;
      IX_NCLR: return 12'h03C;
      IX_RCTL: return 12'h040;
      default: return 12'h084;
    endcase
  endfunction

  function automatic bit board_has_rctl(input logic [11:0] v);
    return (v == BRD_LEGACY) || (v == BRD_A) || (v == BRD_B);
  endfunction

  function automatic int board_trig_bit(input logic [11:0] v);
    return (v == BRD_LEGACY) ? 8 : 2;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output logic              rd_ok,
  output logic              wr_ok
);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(reg_offset(i)));
  end

  assign rd_ok = |(hit & RD_MASK);
  assign wr_ok = |(hit & WR_MASK);

endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
  parameter int                LOCK_W = 16,
  parameter logic [LOCK_W-1:0] KEY    = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [LOCK_W-1:0] wdata,
  output logic [LOCK_W-1:0] lock_q,
  output logic              unlocked
);

  always_ff @(posedge clk) begin
    if (rst)
      lock_q <= '0;
    else if (we)
      lock_q <= (wdata == KEY) ? KEY : {1'b0, wdata[LOCK_W-2:0]};
  end

  assign unlocked = (lock_q == KEY);

  AST_LOCK_MISS_TOPBIT: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata != KEY)) |=> !lock_q[LOCK_W-1]); // R5

  AST_LOCK_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata == KEY)) |=> unlocked); // R5

endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (set_we)
      q <= q | d;
    else if (clr_we)
      q <= q & ~d;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((q & $past(d)) == $past(d))); // R6, R7

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((q & $past(d)) == '0)); // R6, R7

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 12,
  parameter int                LOCK_W   = 16,
  parameter logic [LOCK_W-1:0] LOCK_KEY = 16'hA05F,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h1178_0A01,
  parameter logic [DATA_W-1:0] PROC_ID  = 32'h0C00_0191
) (
  input  logic              clk,
  input  logic              por,
  input  logic              soft_rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              reset_req
);

  localparam logic [11:0] VARIANT = ID_VALUE[27:16];
  localparam bit          RCTL_ON = board_has_rctl(VARIANT);
  localparam int          TRIG    = board_trig_bit(VARIANT);

  logic              rst_v;
  logic [NREG-1:0]   hit;
  logic              rd_ok, wr_ok;
  logic [NREG-1:0]   wsel;
  logic [LOCK_W-1:0] lock_q;
  logic              unlocked;
  logic [DATA_W-1:0] led_q, cfg0_q, cfg1_q, flg_q, nv_q, rctl_q, rd_mux;
  logic              req_q;

  assign rst_v = por | soft_rst;
  assign wsel  = wr_en ? hit : '0;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .hit(hit), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  sysctl_lock #(.LOCK_W(LOCK_W), .KEY(LOCK_KEY)) u_lock (
    .clk(clk), .rst(rst_v), .we(wsel[IX_LOCK]), .wdata(wdata[LOCK_W-1:0]),
    .lock_q(lock_q), .unlocked(unlocked)
  );

  sysctl_setclr #(.W(DATA_W)) u_flags (
    .clk(clk), .rst(rst_v), .set_we(wsel[IX_FSET]), .clr_we(wsel[IX_FCLR]),
    .d(wdata), .q(flg_q)
  );

  sysctl_setclr #(.W(DATA_W)) u_nvflags (
    .clk(clk), .rst(por), .set_we(wsel[IX_NSET]), .clr_we(wsel[IX_NCLR]),
    .d(wdata), .q(nv_q)
  );

  always_ff @(posedge clk) begin
    if (rst_v) begin
      led_q  <= '0;
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else begin
      if (wsel[IX_LED])  led_q  <= wdata;
      if (wsel[IX_CFG0]) cfg0_q <= wdata;
      if (wsel[IX_CFG1]) cfg1_q <= wdata;
    end
  end

  if (RCTL_ON) begin : g_rctl
    logic take;
    assign take = wsel[IX_RCTL] & unlocked;

    always_ff @(posedge clk) begin
      if (rst_v) begin
        rctl_q <= '0;
        req_q  <= 1'b0;
      end else begin
        if (take) rctl_q <= wdata;
        req_q <= take & wdata[TRIG];
      end
    end

    AST_RCTL_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst_v)
      (wsel[IX_RCTL] && !unlocked) |=> $stable(rctl_q)); // R8

    AST_REQ_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst_v)
      reset_req |-> $past(wr_en && hit[IX_RCTL] && unlocked && wdata[TRIG])); // R9
  end else begin : g_no_rctl
    assign rctl_q = '0;
    assign req_q  = 1'b0;

    AST_RCTL_RAZ: assert property (@(posedge clk) disable iff (rst_v)
      (rd_en && hit[IX_RCTL]) |=> (rdata == '0 && !err)); // R10
  end

  always_comb begin
    rd_mux = '0;
    if (hit[IX_ID])   rd_mux = ID_VALUE;
    if (hit[IX_LED])  rd_mux = led_q;
    if (hit[IX_LOCK]) rd_mux = DATA_W'(lock_q);
    if (hit[IX_CFG0]) rd_mux = cfg0_q;
    if (hit[IX_CFG1]) rd_mux = cfg1_q;
    if (hit[IX_FSET]) rd_mux = flg_q;
    if (hit[IX_NSET]) rd_mux = nv_q;
    if (hit[IX_RCTL]) rd_mux = rctl_q;
    if (hit[IX_PROC]) rd_mux = PROC_ID;
  end

  always_ff @(posedge clk) begin
    if (rst_v) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_ok ? rd_mux : '0;
      err <= (rd_en & ~rd_ok) | (wr_en & ~wr_ok);
    end
  end

  assign reset_req = req_q;

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst_v)
    !rd_en |=> $stable(rdata)); // R3

  AST_ERR_FROM_ACCESS: assert property (@(posedge clk) disable iff (rst_v)
    err |-> $past(rd_en || wr_en)); // R11

  AST_NV_SURVIVES_SOFT: assert property (@(posedge clk) disable iff (por)
    (soft_rst && !wr_en) |=> $stable(nv_q)); // R2

  AST_POR_CLEARS: assert property (@(posedge clk)
    por |=> (rdata == '0 && !err && !reset_req)); // R1

endmodule

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;

  localparam logic [31:0] ID_MAIN = 32'h1178_0A01;
  localparam logic [31:0] ID_B8   = 32'h2100_0000;
  localparam logic [31:0] ID_RAZ  = 32'h3190_0000;
  localparam logic [31:0] PROC    = 32'h0C00_0191;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        soft_rst = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_b8, rdata_raz;
  logic        err, err_b8, err_raz;
  logic        rreq, rreq_b8, rreq_raz;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  sysctl_regs #(.ID_VALUE(ID_MAIN), .PROC_ID(PROC)) u_sysctl_regs (
    .clk(clk), .por(por), .soft_rst(soft_rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .reset_req(rreq));

  sysctl_regs #(.ID_VALUE(ID_B8), .PROC_ID(PROC)) u_b8 (
    .clk(clk), .por(por), .soft_rst(soft_rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_b8), .err(err_b8), .reset_req(rreq_b8));

  sysctl_regs #(.ID_VALUE(ID_RAZ), .PROC_ID(PROC)) u_raz (
    .clk(clk), .por(por), .soft_rst(soft_rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_raz), .err(err_raz), .reset_req(rreq_raz));

  // vector: {req[3:0], op[1:0], addr[11:0], wdata[31:0], expect[31:0]}
  // op: 0 write ok, 1 read ok, 2 read error, 3 write error
  localparam int NV = 31;
  localparam logic [81:0] VEC [NV] = '{
    {4'd4,  2'd0, 12'h008, 32'hDEADBEEF, 32'h0},        // R4
    {4'd4,  2'd1, 12'h008, 32'h0, 32'hDEADBEEF},
    {4'd4,  2'd0, 12'h028, 32'h12345678, 32'h0},
    {4'd4,  2'd0, 12'h02C, 32'h9ABCDEF0, 32'h0},
    {4'd4,  2'd1, 12'h028, 32'h0, 32'h12345678},
    {4'd4,  2'd1, 12'h02C, 32'h0, 32'h9ABCDEF0},
    {4'd5,  2'd0, 12'h020, 32'h0000A05F, 32'h0},        // R5
    {4'd5,  2'd1, 12'h020, 32'h0, 32'h0000A05F},
    {4'd5,  2'd0, 12'h020, 32'hFFFF1234, 32'h0},
    {4'd5,  2'd1, 12'h020, 32'h0, 32'h00001234},
    {4'd5,  2'd0, 12'h020, 32'h0000C0DE, 32'h0},
    {4'd5,  2'd1, 12'h020, 32'h0, 32'h000040DE},
    {4'd6,  2'd0, 12'h030, 32'h000000F0, 32'h0},        // R6
    {4'd6,  2'd0, 12'h030, 32'h00000003, 32'h0},
    {4'd6,  2'd1, 12'h030, 32'h0, 32'h000000F3},
    {4'd6,  2'd0, 12'h034, 32'h00000011, 32'h0},
    {4'd6,  2'd1, 12'h030, 32'h0, 32'h000000E2},
    {4'd7,  2'd0, 12'h038, 32'h80000001, 32'h0},        // R7
    {4'd7,  2'd0, 12'h03C, 32'h00000001, 32'h0},
    {4'd7,  2'd1, 12'h038, 32'h0, 32'h80000000},
    {4'd11, 2'd2, 12'h034, 32'h0, 32'h0},               // R11
    {4'd11, 2'd2, 12'h010, 32'h0, 32'h0},
    {4'd11, 2'd3, 12'h000, 32'h55555555, 32'h0},
    {4'd11, 2'd3, 12'h044, 32'h55555555, 32'h0},
    {4'd3,  2'd1, 12'h000, 32'h0, ID_MAIN},             // R3
    {4'd3,  2'd1, 12'h084, 32'h0, PROC},
    {4'd8,  2'd0, 12'h040, 32'h00000004, 32'h0},        // R8 locked
    {4'd8,  2'd1, 12'h040, 32'h0, 32'h0},
    {4'd8,  2'd0, 12'h020, 32'h0000A05F, 32'h0},
    {4'd8,  2'd0, 12'h040, 32'h00000010, 32'h0},
    {4'd8,  2'd1, 12'h040, 32'h0, 32'h00000010}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog got=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata", rdata, 32'h0);
    check("R1 err", {31'h0, err}, 32'h0);
    check("R1 reset_req", {31'h0, rreq}, 32'h0);
    por = 1'b0;
    foreach (VEC[i]) ;
    begin
      logic [11:0] offs [7] = '{12'h008, 12'h020, 12'h028, 12'h02C, 12'h030, 12'h038, 12'h040};
      for (int k = 0; k < 7; k++) begin
        bus_rd(offs[k]);
        check($sformatf("R1 reg %03h", offs[k]), rdata, 32'h0);
      end
    end

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [11:0] a;
      logic [31:0] d, e;
      {rq, op, a, d, e} = VEC[i];
      if (op[0] ^ op[1]) bus_rd(a);
      else bus_wr(a, d);
      check($sformatf("R%0d err vec %0d", rq, i), {31'h0, err}, {31'h0, op[1]});
      if (op[0] ^ op[1]) check($sformatf("R%0d data vec %0d", rq, i), rdata, e);
      else check($sformatf("R9 no req vec %0d", i), {31'h0, rreq}, 32'h0);
    end

    // R9: lock open, trigger bit 2 on main variant
    bus_wr(12'h040, 32'h0000_0004);
    check("R9 main pulse", {31'h0, rreq}, 32'h1);
    check("R9 bit8 variant quiet", {31'h0, rreq_b8}, 32'h0);
    check("R10 raz quiet", {31'h0, rreq_raz}, 32'h0);
    @(negedge clk);
    check("R9 pulse one cycle", {31'h0, rreq}, 32'h0);
    bus_wr(12'h040, 32'h0000_0100);
    check("R9 main no pulse on bit8", {31'h0, rreq}, 32'h0);
    check("R9 bit8 variant pulse", {31'h0, rreq_b8}, 32'h1);
    @(negedge clk);
    check("R9 bit8 pulse one cycle", {31'h0, rreq_b8}, 32'h0);
    bus_rd(12'h040);
    check("R8 main rctl", rdata, 32'h0000_0100);
    check("R8 b8 rctl", rdata_b8, 32'h0000_0100);
    check("R10 raz reads zero", rdata_raz, 32'h0);
    check("R10 raz no err", {31'h0, err_raz}, 32'h0);

    // R8: relock then write is ignored
    bus_wr(12'h020, 32'h0);
    bus_wr(12'h040, 32'h0000_0104);
    check("R8 locked no pulse", {31'h0, rreq}, 32'h0);
    check("R8 locked no pulse b8", {31'h0, rreq_b8}, 32'h0);
    bus_rd(12'h040);
    check("R8 locked unchanged", rdata, 32'h0000_0100);

    // R3: rdata holds between reads
    bus_rd(12'h008);
    check("R3 read led", rdata, 32'hDEADBEEF);
    bus_wr(12'h008, 32'h0BAD_F00D);
    repeat (2) @(negedge clk);
    check("R3 rdata held", rdata, 32'hDEADBEEF);

    // R2: soft reset keeps non-volatile flags
    bus_wr(12'h03C, 32'hFFFF_FFFF);
    bus_wr(12'h038, 32'h0000_005A);
    bus_wr(12'h030, 32'h0000_0003);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    bus_rd(12'h038);
    check("R2 nv kept", rdata, 32'h0000_005A);
    bus_rd(12'h030);
    check("R2 flags cleared", rdata, 32'h0);
    bus_rd(12'h008);
    check("R2 led cleared", rdata, 32'h0);
    bus_rd(12'h040);
    check("R2 rctl cleared", rdata, 32'h0);

    // R1: power-on reset clears non-volatile flags too
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    bus_rd(12'h038);
    check("R1 nv cleared by por", rdata, 32'h0);

    finish_run();
  end

endmodule